// File: doc/BRIEF.md
# Infrared Serial Pulse-to-NRZ Receive Decoder

This block sits between an infrared receive line and a UART receiver. The infrared line idles high. A zero bit is sent as one short low pulse near the start of the bit period. A one bit is sent as no pulse at all. The decoder turns this pulse stream back into a level-coded (NRZ) serial stream that the UART can sample in the normal way.

The decoder runs on the system clock. It is paced by the same one-cycle 16x baud strobe that drives the UART's oversampling. A local phase counter steps once per strobe. Each accepted pulse re-aligns the counter to zero. Halfway through each bit, when the counter reaches 8, the decoded bit is written to the output, so the output lags the infrared stream by half a bit.

After a pulse, an acceptance window stays shut for most of the next bit. This rejects spurious edges inside a bit. The window reopens late in the bit, so the next bit's pulse may arrive early or late. A decoder that has seen no pulse for a long run accepts any edge, so it always locks onto a new start bit.

Top module: `irda_sir_rx_decoder`

## Requirements
- R1: While reset is held or `enable` is low, `rxd` is 1 one clock later, the phase counter is 0, no edge is pending, and the decoder is idle.
- R2: On each `baud_tick` with `enable` high and no accepted edge, the phase counter steps by one from 0 to 15 and wraps to 0. Without a tick the counter holds its value.
- R3: An accepted falling edge sets the phase counter to 0 on the tick that consumes it. This re-aligns the later output updates to that edge.
- R4: `rxd` changes only on the tick where the counter steps to 8. It then takes 0 if an edge was accepted since the previous update, and 1 otherwise. A zero bit therefore appears 8 ticks after its pulse.
- R5: An accepted edge shuts the acceptance window. The window opens on the tick where the counter steps to 12 and shuts again where it steps to 8. An edge consumed while the window is shut, and the decoder is not idle, has no effect on the counter or on `rxd`.
- R6: The decoder is idle after reset, after `enable` is low, or after 10 consecutive updates that output 1. When idle, the next edge is accepted whether or not the window is open. An accepted edge ends the idle state.
- R7: The `ir_rx` line passes through a two-flop synchronizer clocked by `clk`. A falling edge found between ticks is held until the next tick consumes it. Several edges between two ticks count as one.
- R8: When no pulse arrives, the counter keeps running and `rxd` is 1 at every update. Back-to-back one bits are therefore produced.
- R9: A pending edge is discarded when `enable` drops. After `enable` returns, that edge does not produce a 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock. The infrared line is sampled and edges are found on this clock. |
| rst_n | input | 1 | Asynchronous active-low reset. It is released synchronously inside the block. |
| enable | input | 1 | Decoder enable. When low, the decoder is held in its idle state. |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate. |
| ir_rx | input | 1 | Raw infrared receive line. It idles high, and a pulse drives it low. |
| rxd | output | 1 | Decoded NRZ serial data for the UART. It idles at 1. |

## Verification
The assertions take three things for granted.
- `baud_tick` is a single-cycle strobe.
- `ir_rx` pulses last at least two system clocks, so the synchronizer catches every pulse.
- Ticks are far enough apart that a pulse ends before the next tick consumes it.

The stimulus keeps within these limits. It spaces ticks four clocks apart or more, and drives each pulse low for two clocks just after a tick. Each pulse then lands as one edge on the following tick. The stimulus also places pulses deliberately:
- inside the shut window;
- after a long idle run;
- twice between two ticks;
- just before `enable` drops.

// File: rtl/irdec_pkg.sv
package irdec_pkg;
  // Default shape of the decoder timing: ticks per bit and event points.
  localparam int DEF_BIT_TICKS   = 16;
  localparam int DEF_SAMPLE_AT   = 8;
  localparam int DEF_WIN_OPEN_AT = 12;
  localparam int DEF_IDLE_BITS   = 10;
  localparam int DEF_SYNC_STAGES = 2;

  // Events produced by the phase tracker for one baud tick.
  typedef struct packed {
    logic accept;   // edge taken, counter re-aligned
    logic sample;   // counter stepped onto the output update point
    logic bit_val;  // decoded value to present at the update point
  } phase_evt_t;
endpackage

// File: rtl/irdec_rst_sync.sv
module irdec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/irdec_edge_sync.sv
module irdec_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic baud_tick,
  input  logic ir_in,
  output logic edge_now
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              pend_q;
  logic              pend_d;
  logic              ir_s;
  logic              fall;

  // Synchronizer chain, idle level is high.
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= ir_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign ir_s = sync_q[STAGES-1];
  assign fall = last_q & ~ir_s;

  // Held edge: set by a fall, cleared by the tick that consumes it.
  always_comb begin
    pend_d = pend_q;
    if (!enable)        pend_d = 1'b0;
    else if (baud_tick) pend_d = 1'b0;
    else if (fall)      pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      last_q <= ir_s;
      pend_q <= pend_d;
    end
  end

  assign edge_now = enable & (fall | pend_q);
endmodule

// File: rtl/irdec_phase.sv
module irdec_phase
  import irdec_pkg::*;
#(
  parameter int BIT_TICKS   = DEF_BIT_TICKS,
  parameter int SAMPLE_AT   = DEF_SAMPLE_AT,
  parameter int WIN_OPEN_AT = DEF_WIN_OPEN_AT,
  parameter int IDLE_BITS   = DEF_IDLE_BITS,
  localparam int CNT_W      = $clog2(BIT_TICKS),
  localparam int IDLE_W     = $clog2(IDLE_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             baud_tick,
  input  logic             edge_now,
  output logic [CNT_W-1:0] cnt,
  output logic             win_open,
  output logic             idle,
  output phase_evt_t       evt
);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(BIT_TICKS - 1);
  localparam logic [CNT_W-1:0]  CNT_SAMP = CNT_W'(SAMPLE_AT);
  localparam logic [CNT_W-1:0]  CNT_OPEN = CNT_W'(WIN_OPEN_AT);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(IDLE_BITS);

  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
  logic              win_q, win_d;
  logic              seen_q, seen_d;
  logic [IDLE_W-1:0] ones_q, ones_d;
  logic              tick_go, accept, sample, open_pt, is_idle;

  // Event decode for the current tick.
  always_comb begin
    tick_go = enable & baud_tick;
    is_idle = (ones_q == IDLE_MAX);
    cnt_inc = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    accept  = tick_go & edge_now & (win_q | is_idle);
    sample  = tick_go & ~accept & (cnt_inc == CNT_SAMP);
    open_pt = tick_go & ~accept & (cnt_inc == CNT_OPEN);
  end

  // Next state.
  always_comb begin
    cnt_d  = cnt_q;
    win_d  = win_q;
    seen_d = seen_q;
    ones_d = ones_q;
    if (!enable) begin
      cnt_d  = '0;
      win_d  = 1'b0;
      seen_d = 1'b0;
      ones_d = IDLE_MAX;
    end else if (accept) begin
      cnt_d  = '0;
      win_d  = 1'b0;
      seen_d = 1'b1;
      ones_d = '0;
    end else if (tick_go) begin
      cnt_d = cnt_inc;
      if (open_pt) win_d = 1'b1;
      if (sample) begin
        win_d  = 1'b0;
        seen_d = 1'b0;
        if (!seen_q && !is_idle) ones_d = ones_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      win_q  <= 1'b0;
      seen_q <= 1'b0;
      ones_q <= IDLE_MAX;
    end else begin
      cnt_q  <= cnt_d;
      win_q  <= win_d;
      seen_q <= seen_d;
      ones_q <= ones_d;
    end
  end

  assign cnt         = cnt_q;
  assign win_open    = win_q;
  assign idle        = is_idle;
  assign evt.accept  = accept;
  assign evt.sample  = sample;
  assign evt.bit_val = ~seen_q;
endmodule

// File: rtl/irdec_nrz_out.sv
module irdec_nrz_out
  import irdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  phase_evt_t evt,
  output logic       rxd
);
  logic rxd_q, rxd_d;

  always_comb begin
    rxd_d = rxd_q;
    if (!enable)         rxd_d = 1'b1;
    else if (evt.sample) rxd_d = evt.bit_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rxd_q <= 1'b1;
    else        rxd_q <= rxd_d;
  end

  assign rxd = rxd_q;
endmodule

// File: rtl/irda_sir_rx_decoder.sv
module irda_sir_rx_decoder
  import irdec_pkg::*;
#(
  parameter int BIT_TICKS   = DEF_BIT_TICKS,
  parameter int SAMPLE_AT   = DEF_SAMPLE_AT,
  parameter int WIN_OPEN_AT = DEF_WIN_OPEN_AT,
  parameter int IDLE_BITS   = DEF_IDLE_BITS,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic baud_tick,
  input  logic ir_rx,
  output logic rxd
);
  localparam int CNT_W = $clog2(BIT_TICKS);

  logic             rst_sync_n;
  logic             edge_now;
  logic [CNT_W-1:0] cnt;
  logic             win_open;
  logic             idle;
  phase_evt_t       evt;

  irdec_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irdec_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .enable    (enable),
    .baud_tick (baud_tick),
    .ir_in     (ir_rx),
    .edge_now  (edge_now)
  );

  irdec_phase #(
    .BIT_TICKS   (BIT_TICKS),
    .SAMPLE_AT   (SAMPLE_AT),
    .WIN_OPEN_AT (WIN_OPEN_AT),
    .IDLE_BITS   (IDLE_BITS)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .enable    (enable),
    .baud_tick (baud_tick),
    .edge_now  (edge_now),
    .cnt       (cnt),
    .win_open  (win_open),
    .idle      (idle),
    .evt       (evt)
  );

  irdec_nrz_out u_out (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .enable (enable),
    .evt    (evt),
    .rxd    (rxd)
  );
endmodule

// File: rtl/irdec_checker.sv
module irdec_checker #(
  parameter int BIT_TICKS   = 16,
  parameter int SAMPLE_AT   = 8,
  parameter int WIN_OPEN_AT = 12,
  localparam int CNT_W      = $clog2(BIT_TICKS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             baud_tick,
  input logic             rxd,
  input logic [CNT_W-1:0] cnt,
  input logic             accept,
  input logic             win_open,
  input logic             idle
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_TICKS - 1);
  localparam logic [CNT_W-1:0] SAMP = CNT_W'(SAMPLE_AT);
  localparam logic [CNT_W-1:0] PRE_OPEN = CNT_W'(WIN_OPEN_AT - 1);

  a_r1_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (rxd && cnt == '0 && idle));

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && baud_tick && !accept) |=>
      cnt == (($past(cnt) == LAST) ? '0 : $past(cnt) + 1'b1));

  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !baud_tick) |=> $stable(cnt));

  a_r3_accept_zero: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> cnt == '0);

  a_r4_rxd_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$stable(rxd)) |-> cnt == SAMP);

  a_r5_shut_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !win_open);

  a_r5_open_point: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && baud_tick && !accept && cnt == PRE_OPEN) |=> win_open);

  a_r6_accept_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !idle);
endmodule

bind irda_sir_rx_decoder irdec_checker #(
  .BIT_TICKS   (BIT_TICKS),
  .SAMPLE_AT   (SAMPLE_AT),
  .WIN_OPEN_AT (WIN_OPEN_AT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .enable    (enable),
  .baud_tick (baud_tick),
  .rxd       (rxd),
  .cnt       (cnt),
  .accept    (evt.accept),
  .win_open  (win_open),
  .idle      (idle)
);

// File: tb/irda_sir_rx_decoder_test.sv
module irda_sir_rx_decoder_test;
  localparam int TICKS = 16;
  localparam int IDLE  = 10;

  typedef struct {
    bit    exp;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic baud_tick = 1'b0;
  logic ir_rx = 1'b1;
  logic rxd;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  item_t sb_q[$];
  bit pending_ev = 1'b0;

  // reference model state
  int m_cnt, m_ones;
  bit m_win, m_seen, m_rxd;

  always #10 clk = ~clk;

  irda_sir_rx_decoder uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .baud_tick(baud_tick), .ir_rx(ir_rx), .rxd(rxd)
  );

  task automatic check(bit act, bit exp, string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rxd=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    m_cnt = 0; m_ones = IDLE; m_win = 0; m_seen = 0; m_rxd = 1;
  endfunction

  function automatic bit model_tick(bit ev);
    if (ev && (m_win || m_ones == IDLE)) begin
      m_cnt = 0; m_seen = 1; m_win = 0; m_ones = 0;
    end else begin
      m_cnt = (m_cnt + 1) % TICKS;
      if (m_cnt == 12) m_win = 1;
      if (m_cnt == 8) begin
        m_rxd = !m_seen;
        if (!m_seen && m_ones < IDLE) m_ones++;
        m_seen = 0;
        m_win = 0;
      end
    end
    return m_rxd;
  endfunction

  // Driver: one tick period of four clocks; optional two-clock pulse after the tick.
  task automatic step(bit pulse, string tag);
    item_t it;
    @(negedge clk);
    baud_tick = 1'b1;
    it.exp = model_tick(pending_ev);
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    baud_tick = 1'b0;
    ir_rx = !pulse;
    @(negedge clk);
    @(negedge clk);
    ir_rx = 1'b1;
    pending_ev = pulse;
  endtask

  // Two pulses between the same pair of ticks.
  task automatic step_double(string tag);
    item_t it;
    @(negedge clk);
    baud_tick = 1'b1;
    it.exp = model_tick(pending_ev);
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); baud_tick = 1'b0; ir_rx = 1'b0;
    repeat (2) @(negedge clk); ir_rx = 1'b1;
    repeat (2) @(negedge clk); ir_rx = 1'b0;
    repeat (2) @(negedge clk); ir_rx = 1'b1;
    pending_ev = 1'b1;
  endtask

  task automatic quiet(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b0, tag);
  endtask

  task automatic send_bit(bit b, string tag);
    step(!b, tag);
    quiet(TICKS - 1, tag);
  endtask

  task automatic send_byte(logic [7:0] d, string tag);
    send_bit(1'b0, tag);
    for (int i = 0; i < 8; i++) send_bit(d[i], tag);
    send_bit(1'b1, tag);
  endtask

  // Monitor: compare after every enabled tick.
  initial begin
    item_t it;
    forever begin
      @(posedge clk iff (baud_tick === 1'b1 && enable === 1'b1));
      @(negedge clk);
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        check(rxd, it.exp, it.tag);
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: expired, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check(rxd, 1'b1, "R1 reset level");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rxd, 1'b1, "R1 after release");
    enable = 1'b1;

    quiet(40, "R8 idle ones");
    quiet(7, "R2 free-running phase");
    send_byte(8'hA5, "R4 frame A5");
    send_byte(8'h00, "R4 frame 00");
    send_byte(8'hFF, "R8 frame FF");
    quiet(20, "R8 gap");

    // R3: realign on a pulse at an arbitrary phase, then two more bits
    quiet(5, "R3 pre");
    send_bit(1'b0, "R3 realign");
    quiet(3, "R3 offset");
    send_bit(1'b0, "R3 realign second");
    quiet(40, "R3 settle");

    // R5: a zero bit followed by spurious pulses inside the shut window
    send_bit(1'b0, "R5 lead zero");
    step(1'b1, "R5 spur bit start");
    quiet(2, "R5 spur");
    step(1'b1, "R5 spur early");
    quiet(4, "R5 spur");
    step(1'b1, "R5 spur mid");
    quiet(TICKS, "R5 after spur");
    send_bit(1'b1, "R5 ones");

    // R6: reach idle through ten one-bits, then an edge off the window
    send_bit(1'b0, "R6 zero");
    quiet(IDLE * TICKS + 9, "R6 ones to idle");
    send_bit(1'b0, "R6 idle accept");
    quiet(30, "R6 settle");

    // R7: two pulses between one pair of ticks act as one edge
    step_double("R7 double");
    quiet(TICKS + 8, "R7 after double");
    quiet(40, "R7 settle");

    // R9: disable while rxd is 0 and an edge is pending
    send_bit(1'b0, "R9 zero");
    step(1'b0, "R9 pre");
    step(1'b1, "R9 pulse before disable");
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(rxd, 1'b1, "R1 disable level");
    check(rxd, 1'b1, "R9 disable drops rxd high");
    enable = 1'b1;
    model_reset();
    pending_ev = 1'b0;
    quiet(40, "R9 pending discarded");

    send_byte(8'h3C, "R4 frame 3C after re-enable");
    quiet(20, "R8 tail");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule